// File: doc/BRIEF.md
# E1 Sa-bit Multiframe Buffer

This block collects and inserts the five national bits (Sa4 to Sa8) carried in the time slot 0 service word of an E1 stream. The service word is sent in every other frame. On the receive side, each Sa position is shifted into its own accumulator over the eight service words of a CRC multiframe, or over eight doubleframes. At every receive multiframe begin, all five accumulators are copied at once into processor-visible registers, and a sticky interrupt flag is raised.

On the transmit side, the processor writes five transmit registers. At every transmit multiframe begin, these registers are copied into shadow registers and a second sticky flag is raised. The shadow contents then go out, one bit per service word, in the following multiframe. If the processor writes nothing new, the previous data is sent again. Frame and multiframe alignment come from the surrounding framer as strobes. When multiframe access is disabled, only a single-word path is active: the last received service word is visible, and a fixed word is inserted. When a transparent time slot 0 mode is on, the framer's own bits pass through unchanged.

Top module: `e1_sa_mfbuf`

## Requirements
- R1: A bit slot strobe with slot index s (0 to 7 for bits 1 to 8 of time slot 0) and s in 3..7 carries Sa(s+1). Each received Sa bit is shifted into the LSB of its accumulator, so that after eight service words the first word's bit sits in bit 7.
- R2: With enable high, a receive multiframe begin strobe copies all five accumulators into rx_sa_o in the following cycle. rx_sa_o[8n+7:8n] holds Sa(4+n). At all other times rx_sa_o holds its value. It resets to zero.
- R3: The receive flag rmb_o is set on the same update. It stays set until irq_clr_i[0] is pulsed, and setting wins over a clear in the same cycle. It resets to zero.
- R4: With enable high, a transmit multiframe begin copies the five transmit registers into shadow registers and sets xmb_o. xmb_o is sticky and cleared by irq_clr_i[1], with set winning over clear.
- R5: In the k-th service word after a transmit multiframe begin (k = 0..7), the slot for Sa(4+n) drives shadow register n bit 7-k on tx_bit_o. All other slots and non-strobe cycles pass tx_ts0_i.
- R6: If no transmit register is written between two transmit multiframe begins, the same Sa data is sent again.
- R7: While transp_i is high, tx_bit_o equals tx_ts0_i in every cycle.
- R8: With enable low, multiframe begins neither update rx_sa_o nor set either flag, and the Sa slots transmit tx_sw_i[n] for Sa(4+n) in every service word.
- R9: rx_sw_o[n] takes the Sa(4+n) bit of each received service word, whatever the enable setting.
- R10: A write to a transmit register (tx_wsel_i 0..4 for Sa4..Sa8) does not change the transmitted bits until the next transmit multiframe begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ena_i | input | 1 | Multiframe register access enable |
| transp_i | input | 1 | Time slot 0 transparent mode |
| rx_stb_i | input | 1 | Receive service-word bit slot strobe |
| rx_slot_i | input | 3 | Receive bit slot index |
| rx_bit_i | input | 1 | Received bit in that slot |
| rx_mfb_i | input | 1 | Receive multiframe begin strobe |
| tx_stb_i | input | 1 | Transmit service-word bit slot strobe |
| tx_slot_i | input | 3 | Transmit bit slot index |
| tx_ts0_i | input | 1 | Framer's time slot 0 bit for this cycle |
| tx_mfb_i | input | 1 | Transmit multiframe begin strobe |
| tx_wr_i | input | 1 | Transmit register write |
| tx_wsel_i | input | 3 | Transmit register select |
| tx_wdata_i | input | 8 | Transmit register write data |
| tx_sw_i | input | 5 | Single-word Sa bits used when enable is low |
| irq_clr_i | input | 2 | Write-1 clear: bit 0 rmb, bit 1 xmb |
| rx_sa_o | output | 40 | Received multiframe Sa registers |
| rx_sw_o | output | 5 | Sa bits of the last service word |
| tx_bit_o | output | 1 | Outgoing time slot 0 bit |
| rmb_o | output | 1 | Receive multiframe begin flag |
| xmb_o | output | 1 | Transmit multiframe begin flag |

## Verification
The hardest case to reach is a processor write that lands partway through an outgoing multiframe. It must leave the bits on the line untouched until the next boundary. The stimulus writes new random values after the third service word and checks the rest of the multiframe against the old shadow data. It then checks the following multiframe against the new data. A set and a clear of the same flag in one cycle, and multiframe begins with enable low, are driven directly.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int N_SA     = 5;
  localparam int MF_WORDS = 8;
  localparam int SLOT_W   = 3;
  localparam int FIRST_SA = 3;
endpackage

// File: rtl/sa_irq_flag.sv
module sa_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/sa_rx_collect.sv
module sa_rx_collect #(
  parameter int N_SA     = e1_sa_pkg::N_SA,
  parameter int MF_WORDS = e1_sa_pkg::MF_WORDS,
  parameter int SLOT_W   = e1_sa_pkg::SLOT_W,
  parameter int FIRST_SA = e1_sa_pkg::FIRST_SA
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ena_i,
  input  logic                       stb_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic                       bit_i,
  input  logic                       mfb_i,
  output logic [N_SA*MF_WORDS-1:0]   mf_o,
  output logic [N_SA-1:0]            sw_o
);
  for (genvar n = 0; n < N_SA; n++) begin : g_sa
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(FIRST_SA + n);
    logic [MF_WORDS-1:0] acc_q;
    logic                hit;
    assign hit = stb_i && (slot_i == MY_SLOT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q   <= '0;
        sw_o[n] <= 1'b0;
      end else if (hit) begin
        acc_q   <= {acc_q[MF_WORDS-2:0], bit_i};
        sw_o[n] <= bit_i;
      end
    end

    // copy takes the pre-shift accumulator if a slot strobe coincides
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               mf_o[n*MF_WORDS +: MF_WORDS] <= '0;
      else if (mfb_i && ena_i)   mf_o[n*MF_WORDS +: MF_WORDS] <= acc_q;
    end
  end
endmodule

// File: rtl/sa_tx_insert.sv
module sa_tx_insert #(
  parameter int N_SA     = e1_sa_pkg::N_SA,
  parameter int MF_WORDS = e1_sa_pkg::MF_WORDS,
  parameter int SLOT_W   = e1_sa_pkg::SLOT_W,
  parameter int FIRST_SA = e1_sa_pkg::FIRST_SA
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ena_i,
  input  logic                  transp_i,
  input  logic                  mfb_i,
  input  logic                  stb_i,
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic                  ts0_i,
  input  logic                  wr_i,
  input  logic [2:0]            wsel_i,
  input  logic [MF_WORDS-1:0]   wdata_i,
  input  logic [N_SA-1:0]       sw_i,
  output logic                  bit_o
);
  localparam int CNT_W = (MF_WORDS > 1) ? $clog2(MF_WORDS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'((1 << SLOT_W) - 1);
  localparam logic [CNT_W-1:0]  LAST_WORD = CNT_W'(MF_WORDS - 1);

  logic [CNT_W-1:0] word_q;
  logic [N_SA-1:0]  hit;
  logic [N_SA-1:0]  val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             word_q <= '0;
    else if (mfb_i)                          word_q <= '0;
    else if (stb_i && slot_i == LAST_SLOT)   word_q <= (word_q == LAST_WORD) ? '0 : word_q + 1'b1;
  end

  for (genvar n = 0; n < N_SA; n++) begin : g_sa
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(FIRST_SA + n);
    logic [MF_WORDS-1:0] xreg_q;
    logic [MF_WORDS-1:0] shadow_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        xreg_q <= '0;
      else if (wr_i && wsel_i == 3'(n))   xreg_q <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               shadow_q <= '0;
      else if (mfb_i && ena_i)   shadow_q <= xreg_q;
    end

    assign hit[n] = stb_i && (slot_i == MY_SLOT);
    assign val[n] = ena_i ? shadow_q[LAST_WORD - word_q] : sw_i[n];
  end

  always_comb begin
    bit_o = ts0_i;
    if (!transp_i && |hit) bit_o = |(hit & val);
  end
endmodule

// File: rtl/e1_sa_mfbuf.sv
module e1_sa_mfbuf #(
  parameter int N_SA     = e1_sa_pkg::N_SA,
  parameter int MF_WORDS = e1_sa_pkg::MF_WORDS,
  parameter int SLOT_W   = e1_sa_pkg::SLOT_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ena_i,
  input  logic                      transp_i,
  input  logic                      rx_stb_i,
  input  logic [SLOT_W-1:0]         rx_slot_i,
  input  logic                      rx_bit_i,
  input  logic                      rx_mfb_i,
  input  logic                      tx_stb_i,
  input  logic [SLOT_W-1:0]         tx_slot_i,
  input  logic                      tx_ts0_i,
  input  logic                      tx_mfb_i,
  input  logic                      tx_wr_i,
  input  logic [2:0]                tx_wsel_i,
  input  logic [MF_WORDS-1:0]       tx_wdata_i,
  input  logic [N_SA-1:0]           tx_sw_i,
  input  logic [1:0]                irq_clr_i,
  output logic [N_SA*MF_WORDS-1:0]  rx_sa_o,
  output logic [N_SA-1:0]           rx_sw_o,
  output logic                      tx_bit_o,
  output logic                      rmb_o,
  output logic                      xmb_o
);
  localparam int FIRST_SA = e1_sa_pkg::FIRST_SA;

  sa_rx_collect #(.N_SA(N_SA), .MF_WORDS(MF_WORDS), .SLOT_W(SLOT_W), .FIRST_SA(FIRST_SA)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_i), .stb_i(rx_stb_i), .slot_i(rx_slot_i),
    .bit_i(rx_bit_i), .mfb_i(rx_mfb_i), .mf_o(rx_sa_o), .sw_o(rx_sw_o)
  );

  sa_tx_insert #(.N_SA(N_SA), .MF_WORDS(MF_WORDS), .SLOT_W(SLOT_W), .FIRST_SA(FIRST_SA)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_i), .transp_i(transp_i), .mfb_i(tx_mfb_i),
    .stb_i(tx_stb_i), .slot_i(tx_slot_i), .ts0_i(tx_ts0_i), .wr_i(tx_wr_i), .wsel_i(tx_wsel_i),
    .wdata_i(tx_wdata_i), .sw_i(tx_sw_i), .bit_o(tx_bit_o)
  );

  sa_irq_flag u_rmb (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(rx_mfb_i && ena_i),
                     .clr_i(irq_clr_i[0]), .flag_o(rmb_o));
  sa_irq_flag u_xmb (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(tx_mfb_i && ena_i),
                     .clr_i(irq_clr_i[1]), .flag_o(xmb_o));
endmodule

// File: rtl/e1_sa_mfbuf_chk.sv
module e1_sa_mfbuf_chk #(
  parameter int N_SA     = e1_sa_pkg::N_SA,
  parameter int MF_WORDS = e1_sa_pkg::MF_WORDS
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      ena_i,
  input logic                      transp_i,
  input logic                      rx_mfb_i,
  input logic                      tx_mfb_i,
  input logic                      tx_ts0_i,
  input logic [1:0]                irq_clr_i,
  input logic [N_SA*MF_WORDS-1:0]  rx_sa_o,
  input logic                      tx_bit_o,
  input logic                      rmb_o,
  input logic                      xmb_o
);
  // R2
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_mfb_i && ena_i) |=> $stable(rx_sa_o));
  // R3
  rmb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mfb_i && ena_i) |=> rmb_o);
  // R3
  rmb_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i[0] && !(rx_mfb_i && ena_i)) |=> !rmb_o);
  // R4
  xmb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mfb_i && ena_i) |=> xmb_o);
  // R7
  transp_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transp_i |-> (tx_bit_o == tx_ts0_i));
  // R8
  no_flag_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_i && !rmb_o && !xmb_o) |=> (!rmb_o && !xmb_o));
endmodule

bind e1_sa_mfbuf e1_sa_mfbuf_chk #(.N_SA(N_SA), .MF_WORDS(MF_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_i), .transp_i(transp_i), .rx_mfb_i(rx_mfb_i),
  .tx_mfb_i(tx_mfb_i), .tx_ts0_i(tx_ts0_i), .irq_clr_i(irq_clr_i), .rx_sa_o(rx_sa_o),
  .tx_bit_o(tx_bit_o), .rmb_o(rmb_o), .xmb_o(xmb_o)
);

// File: tb/e1_sa_mfbuf_tb_top.sv
module e1_sa_mfbuf_tb_top;
  logic clk = 0, rst_ni = 0;
  logic ena = 0, transp = 0;
  logic rx_stb = 0, rx_bit = 0, rx_mfb = 0;
  logic [2:0] rx_slot = 0;
  logic tx_stb = 0, tx_ts0 = 0, tx_mfb = 0, tx_wr = 0;
  logic [2:0] tx_slot = 0, tx_wsel = 0;
  logic [7:0] tx_wdata = 0;
  logic [4:0] tx_sw = 0;
  logic [1:0] irq_clr = 0;
  logic [39:0] rx_sa;
  logic [4:0] rx_sw;
  logic tx_bit, rmb, xmb;
  int checks = 0, errors = 0;
  logic [39:0] rx_exp, tx_regs, tx_shadow;

  always #2.5 clk = ~clk;

  e1_sa_mfbuf dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ena_i(ena), .transp_i(transp),
    .rx_stb_i(rx_stb), .rx_slot_i(rx_slot), .rx_bit_i(rx_bit), .rx_mfb_i(rx_mfb),
    .tx_stb_i(tx_stb), .tx_slot_i(tx_slot), .tx_ts0_i(tx_ts0), .tx_mfb_i(tx_mfb),
    .tx_wr_i(tx_wr), .tx_wsel_i(tx_wsel), .tx_wdata_i(tx_wdata), .tx_sw_i(tx_sw),
    .irq_clr_i(irq_clr), .rx_sa_o(rx_sa), .rx_sw_o(rx_sw), .tx_bit_o(tx_bit),
    .rmb_o(rmb), .xmb_o(xmb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tx(input logic [39:0] sh, input int w, input int s,
                                  input logic ts0, input logic en, input logic tp,
                                  input logic [4:0] sw);
    if (tp || s < 3) return ts0;
    return en ? sh[8*(s-3) + 7 - w] : sw[s-3];
  endfunction

  task automatic pulse_rx_mfb();
    @(posedge clk); #1 rx_mfb = 1;
    @(posedge clk); #1 rx_mfb = 0;
  endtask

  task automatic pulse_tx_mfb();
    @(posedge clk); #1 tx_mfb = 1;
    @(posedge clk); #1 tx_mfb = 0;
  endtask

  task automatic clr_flags(input logic [1:0] m);
    @(posedge clk); #1 irq_clr = m;
    @(posedge clk); #1 irq_clr = 0;
  endtask

  // R1 R9: send one multiframe of service words, Sa bits from d
  task automatic send_rx_mf(input logic [39:0] d);
    for (int w = 0; w < 8; w++) begin
      for (int s = 0; s < 8; s++) begin
        @(posedge clk); #1;
        rx_stb = 1; rx_slot = 3'(s);
        rx_bit = (s >= 3) ? d[8*(s-3) + 7 - w] : 1'($urandom);
      end
      @(posedge clk); #1 rx_stb = 0;
    end
    @(negedge clk);
    for (int n = 0; n < 5; n++) chk("R9 rx_sw", 64'(rx_sw[n]), 64'(d[8*n]));
  endtask

  task automatic write_tx(input logic [39:0] v);
    for (int n = 0; n < 5; n++) begin
      @(posedge clk); #1 tx_wr = 1; tx_wsel = 3'(n); tx_wdata = v[8*n +: 8];
    end
    @(posedge clk); #1 tx_wr = 0;
  endtask

  // R5: run one outgoing multiframe; optional mid-way write after word 2 (R10)
  task automatic run_tx_mf(input logic [39:0] sh, input string req, input bit mid_wr,
                           input logic [39:0] newv);
    for (int w = 0; w < 8; w++) begin
      if (mid_wr && w == 3) write_tx(newv);
      for (int s = 0; s < 8; s++) begin
        @(posedge clk); #1;
        tx_stb = 1; tx_slot = 3'(s); tx_ts0 = 1'($urandom);
        @(negedge clk);
        chk(req, 64'(tx_bit), 64'(exp_tx(sh, w, s, tx_ts0, ena, transp, tx_sw)));
      end
      @(posedge clk); #1 tx_stb = 0; tx_ts0 = 1'($urandom);
      @(negedge clk);
      chk(req, 64'(tx_bit), 64'(tx_ts0));
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5a6b));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk("R2 reset rx_sa", 64'(rx_sa), 0);
    chk("R3 reset rmb", 64'(rmb), 0);
    chk("R4 reset xmb", 64'(xmb), 0);
    chk("R9 reset rx_sw", 64'(rx_sw), 0);

    ena = 1;
    // R1 R2 R3: random multiframes plus all-ones / alternating patterns
    for (int i = 0; i < 5; i++) begin
      rx_exp = (i == 0) ? 40'hff_ffff_ffff : (i == 1) ? 40'h80_0180_0155 : {$urandom, 8'($urandom)};
      send_rx_mf(rx_exp);
      chk("R2 rx hold before mfb", 64'(rx_sa), 64'((i == 0) ? 40'h0 : rx_sa));
      pulse_rx_mfb();
      @(negedge clk);
      chk("R1 R2 rx_sa", 64'(rx_sa), 64'(rx_exp));
      chk("R3 rmb set", 64'(rmb), 1);
      clr_flags(2'b01);
      @(negedge clk);
      chk("R3 rmb clear", 64'(rmb), 0);
    end
    // R3: set wins over clear
    @(posedge clk); #1 rx_mfb = 1; irq_clr = 2'b01;
    @(posedge clk); #1 rx_mfb = 0; irq_clr = 0;
    @(negedge clk);
    chk("R3 set over clear", 64'(rmb), 1);
    clr_flags(2'b01);

    // R4 R5
    tx_regs = {$urandom, 8'($urandom)};
    write_tx(tx_regs);
    pulse_tx_mfb();
    @(negedge clk);
    chk("R4 xmb set", 64'(xmb), 1);
    tx_shadow = tx_regs;
    clr_flags(2'b10);
    @(negedge clk);
    chk("R4 xmb clear", 64'(xmb), 0);
    // R10: mid-multiframe write must not alter current bits
    tx_regs = {$urandom, 8'($urandom)};
    run_tx_mf(tx_shadow, "R5 R10 tx bits", 1, tx_regs);
    pulse_tx_mfb();
    tx_shadow = tx_regs;
    run_tx_mf(tx_shadow, "R10 new data after mfb", 0, 0);
    // R6: no write, repeat
    pulse_tx_mfb();
    run_tx_mf(tx_shadow, "R6 repeat", 0, 0);
    clr_flags(2'b10);

    // R7
    transp = 1;
    pulse_tx_mfb();
    run_tx_mf(tx_shadow, "R7 transparent", 0, 0);
    transp = 0;
    clr_flags(2'b11);

    // R8: enable low
    ena = 0;
    tx_sw = 5'b10110;
    rx_exp = rx_sa;
    send_rx_mf(40'h12_3456_789a);
    pulse_rx_mfb();
    pulse_tx_mfb();
    @(negedge clk);
    chk("R8 rx_sa frozen", 64'(rx_sa), 64'(rx_exp));
    chk("R8 no rmb", 64'(rmb), 0);
    chk("R8 no xmb", 64'(xmb), 0);
    run_tx_mf(tx_shadow, "R8 single word tx", 0, 0);
    tx_sw = 5'b01001;
    run_tx_mf(tx_shadow, "R8 single word tx", 0, 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule